// File: doc/BRIEF.md
# Non-multiplexed chip-select bus controller

This block is a local bus master for simple external memories such as flash, EEPROM or SRAM. It takes one read or write request at a time from a host-side request/response port and runs it as a single tenure on an external bus. The address, the write data and a read/write direction pin are driven together. The active-low chip select of the chosen region stays low for a programmed number of bus clocks.

Each region has its own settings, supplied as static configuration inputs by the surrounding register block:
- an enable,
- separate read and write wait counts,
- separate read and write byte-reversal enables, used for endian conversion,
- read-only and write-only protection.

A master enable gates the whole controller. An access that breaks a region's protection rule never reaches the bus. Such an access is reported through an error response and a protection interrupt, and each has its own enable. A request to a disabled region, or any request while the master enable is clear, is refused without any bus activity.

Top module: `lbc_top`

## Requirements
- R1: While reset is asserted, every chip select is high, `req_ready` is high, and `rsp_done` and `prot_irq` are low.
- R2: A permitted read accepted at a clock edge drives its region's chip select low, and only that one, starting at the next clock. The chip select stays low for exactly `cfg_rd_wait[region]`+1 clocks, with `bus_rnw`=1, `bus_wdata_oe`=0 and `bus_addr` equal to the request address.
- R3: A permitted write behaves as R2 but uses `cfg_wr_wait[region]`, with `bus_rnw`=0 and `bus_wdata_oe`=1. `bus_wdata` carries the request data.
- R4: A wait count of zero still gives a chip-select assertion of exactly one clock.
- R5: In the first clock after the chip select rises, `rsp_done` is high for exactly one clock with `rsp_err`=0. For a read, `rsp_rdata` then holds the `bus_rdata` value present during the last chip-select clock.
- R6: When the region's swap enable for the access direction is 1, the bytes are reversed: byte lane i (bits 8i+7..8i) maps to lane DW/8-1-i. The write swap applies to the data on `bus_wdata`, and the read swap applies to `rsp_rdata`. When the enable is 0, data passes unchanged.
- R7: A write to a region with `cfg_rd_only` set issues no chip select. The next clock gives `rsp_done` with `rsp_err`=`cfg_berr_en` and `prot_irq`=`cfg_irq_en`.
- R8: A read from a region with `cfg_wr_only` set issues no chip select. The next clock gives `rsp_done` with `rsp_err`=`cfg_berr_en` and `prot_irq`=`cfg_irq_en`.
- R9: A request to a region whose `cfg_cs_en` bit is 0, or any request while `cfg_master_en`=0, issues no chip select. The next clock gives `rsp_done` with `rsp_err`=1 and `prot_irq`=0.
- R10: At most one chip select is low at any time. `bus_addr`, `bus_rnw` and `bus_wdata` do not change while a chip select stays low.
- R11: `req_ready` is high only while no request is in progress. It is low from the clock after acceptance through the `rsp_done` clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master_en | input | 1 | Controller-wide enable |
| cfg_cs_en | input | NREG | Per-region enable |
| cfg_rd_wait | input | NREG*WSW | Per-region read wait count |
| cfg_wr_wait | input | NREG*WSW | Per-region write wait count |
| cfg_rd_swap | input | NREG | Per-region read byte reversal |
| cfg_wr_swap | input | NREG | Per-region write byte reversal |
| cfg_rd_only | input | NREG | Per-region read-only protection |
| cfg_wr_only | input | NREG | Per-region write-only protection |
| cfg_berr_en | input | 1 | Report violations as error responses |
| cfg_irq_en | input | 1 | Report violations through the interrupt |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | log2(NREG) | Target region |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Error response, valid with rsp_done |
| rsp_rdata | output | DW | Read data, valid with rsp_done |
| prot_irq | output | 1 | Protection violation interrupt pulse |
| bus_cs_n | output | NREG | Active-low chip selects |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_addr | output | AW | External address |
| bus_wdata | output | DW | External write data |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata | input | DW | External read data |

## Verification
The assertions take three things for granted about the inputs:
- the configuration inputs do not change while a request is in progress,
- `req_region` is below NREG,
- a new request is presented only while `req_ready` is high.

The stimulus respects all three. It changes the configuration only between transactions, while the controller is idle, and draws regions from the legal range. It waits for every response before raising the next request. Within an access, the bench changes `bus_rdata` on every clock, so the data capture point is observable.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BUS  = 2'd1,
        PH_RESP = 2'd2
    } lbc_phase_e;

endpackage

// File: rtl/lbc_guard.sv
module lbc_guard #(
    parameter int NREG = 4,
    parameter int RGW  = 2
) (
    input  logic            master_en,
    input  logic [NREG-1:0] cs_en,
    input  logic [NREG-1:0] rd_only,
    input  logic [NREG-1:0] wr_only,
    input  logic [RGW-1:0]  region,
    input  logic            write,
    input  logic            berr_en,
    input  logic            irq_en,
    output logic            issue,
    output logic            err,
    output logic            irq
);

    logic blocked;
    logic violation;

    always_comb begin
        blocked   = !(master_en && cs_en[region]);
        violation = write ? rd_only[region] : wr_only[region];
        issue     = !blocked && !violation;
        err       = blocked || (violation && berr_en);
        irq       = !blocked && violation && irq_en;
    end

endmodule

// File: rtl/lbc_swap.sv
module lbc_swap #(
    parameter int DW = 32
) (
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    localparam int NB = DW / 8;

    logic [DW-1:0] reversed;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign reversed[8*b +: 8] = din[8*(NB-1-b) +: 8];
    end

    assign dout = en ? reversed : din;

endmodule

// File: rtl/lbc_seq.sv
module lbc_seq
    import lbc_pkg::*;
#(
    parameter int NREG = 4,
    parameter int RGW  = 2,
    parameter int AW   = 24,
    parameter int DW   = 32,
    parameter int WSW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [RGW-1:0]  req_region,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [WSW-1:0]  req_wait,
    input  logic            issue,
    input  logic            deny_err,
    input  logic            deny_irq,
    input  logic [DW-1:0]   bus_rdata,
    output logic            ready,
    output logic            done,
    output logic            err,
    output logic            irq,
    output logic [RGW-1:0]  region_q,
    output logic [DW-1:0]   rdata_raw,
    output logic [NREG-1:0] bus_cs_n,
    output logic            bus_rnw,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    output logic            bus_wdata_oe
);

    typedef struct packed {
        lbc_phase_e     phase;
        logic [WSW-1:0] cnt;
        logic [RGW-1:0] region;
        logic           write;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [DW-1:0]  rdata;
        logic           err;
        logic           irq;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.region = req_region;
                    st_d.write  = req_write;
                    st_d.addr   = req_addr;
                    st_d.wdata  = req_wdata;
                    st_d.cnt    = req_wait;
                    if (issue) begin
                        st_d.phase = PH_BUS;
                        st_d.err   = 1'b0;
                        st_d.irq   = 1'b0;
                    end else begin
                        st_d.phase = PH_RESP;
                        st_d.err   = deny_err;
                        st_d.irq   = deny_irq;
                    end
                end
            end
            PH_BUS: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_RESP;
                    if (!st_q.write) begin
                        st_d.rdata = bus_rdata;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_RESP: begin
                st_d.phase = PH_IDLE;
                st_d.err   = 1'b0;
                st_d.irq   = 1'b0;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic on_bus;
    assign on_bus = (st_q.phase == PH_BUS);

    for (genvar g = 0; g < NREG; g++) begin : g_cs
        assign bus_cs_n[g] = !(on_bus && (st_q.region == RGW'(g)));
    end

    assign ready        = (st_q.phase == PH_IDLE);
    assign done         = (st_q.phase == PH_RESP);
    assign err          = done && st_q.err;
    assign irq          = done && st_q.irq;
    assign region_q     = st_q.region;
    assign rdata_raw    = st_q.rdata;
    assign bus_rnw      = !st_q.write;
    assign bus_addr     = st_q.addr;
    assign bus_wdata    = st_q.wdata;
    assign bus_wdata_oe = on_bus && st_q.write;

    logic cs_any;
    assign cs_any = !(&bus_cs_n);

    assert_one_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    assert_bus_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_any && $past(cs_any)) |-> ($stable(bus_addr) && $stable(bus_rnw) && $stable(bus_wdata)));

    assert_cs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_any && st_q.cnt != '0) |=> cs_any);

    assert_resp_after_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_any) |-> (done && !err));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_deny_no_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && !issue) |=> (done && !cs_any));

    assert_irq_only_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && !cs_any));

endmodule

// File: rtl/lbc_top.sv
module lbc_top #(
    parameter int NREG = 4,
    parameter int AW   = 24,
    parameter int DW   = 32,
    parameter int WSW  = 4,
    localparam int RGW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_master_en,
    input  logic [NREG-1:0]           cfg_cs_en,
    input  logic [NREG-1:0][WSW-1:0]  cfg_rd_wait,
    input  logic [NREG-1:0][WSW-1:0]  cfg_wr_wait,
    input  logic [NREG-1:0]           cfg_rd_swap,
    input  logic [NREG-1:0]           cfg_wr_swap,
    input  logic [NREG-1:0]           cfg_rd_only,
    input  logic [NREG-1:0]           cfg_wr_only,
    input  logic                      cfg_berr_en,
    input  logic                      cfg_irq_en,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [RGW-1:0]            req_region,
    input  logic [AW-1:0]             req_addr,
    input  logic [DW-1:0]             req_wdata,
    output logic                      rsp_done,
    output logic                      rsp_err,
    output logic [DW-1:0]             rsp_rdata,
    output logic                      prot_irq,
    output logic [NREG-1:0]           bus_cs_n,
    output logic                      bus_rnw,
    output logic [AW-1:0]             bus_addr,
    output logic [DW-1:0]             bus_wdata,
    output logic                      bus_wdata_oe,
    input  logic [DW-1:0]             bus_rdata
);

    logic           issue, deny_err, deny_irq;
    logic [WSW-1:0] sel_wait;
    logic [DW-1:0]  wdata_lanes;
    logic [DW-1:0]  rdata_raw;
    logic [RGW-1:0] region_q;

    assign sel_wait = req_write ? cfg_wr_wait[req_region] : cfg_rd_wait[req_region];

    lbc_guard #(.NREG(NREG), .RGW(RGW)) i_guard (
        .master_en (cfg_master_en),
        .cs_en     (cfg_cs_en),
        .rd_only   (cfg_rd_only),
        .wr_only   (cfg_wr_only),
        .region    (req_region),
        .write     (req_write),
        .berr_en   (cfg_berr_en),
        .irq_en    (cfg_irq_en),
        .issue     (issue),
        .err       (deny_err),
        .irq       (deny_irq)
    );

    lbc_swap #(.DW(DW)) i_wswap (
        .en   (cfg_wr_swap[req_region]),
        .din  (req_wdata),
        .dout (wdata_lanes)
    );

    lbc_seq #(.NREG(NREG), .RGW(RGW), .AW(AW), .DW(DW), .WSW(WSW)) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_region   (req_region),
        .req_addr     (req_addr),
        .req_wdata    (wdata_lanes),
        .req_wait     (sel_wait),
        .issue        (issue),
        .deny_err     (deny_err),
        .deny_irq     (deny_irq),
        .bus_rdata    (bus_rdata),
        .ready        (req_ready),
        .done         (rsp_done),
        .err          (rsp_err),
        .irq          (prot_irq),
        .region_q     (region_q),
        .rdata_raw    (rdata_raw),
        .bus_cs_n     (bus_cs_n),
        .bus_rnw      (bus_rnw),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_wdata_oe (bus_wdata_oe)
    );

    lbc_swap #(.DW(DW)) i_rswap (
        .en   (cfg_rd_swap[region_q]),
        .din  (rdata_raw),
        .dout (rsp_rdata)
    );

endmodule

// File: tb/test_lbc_top.sv
`timescale 1ns/1ps
module test_lbc_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            master;
    logic [3:0]      en, rsw, wsw, ro, wo;
    logic [3:0][3:0] rdw, wrw;
    logic            berr, irqen;
    logic            valid = 1'b0, wr = 1'b0;
    logic [1:0]      rg = '0;
    logic [23:0]     addr = '0;
    logic [31:0]     wdata = '0, rdata_in = '0;
    logic            ready, done, err, irq, rnw, oe;
    logic [31:0]     rdata, bwdata;
    logic [23:0]     baddr;
    logic [3:0]      cs_n;

    int checks = 0, errors = 0;
    bit finished = 0;

    lbc_top i_lbc_top (
        .clk(clk), .rst_n(rst_n), .cfg_master_en(master), .cfg_cs_en(en),
        .cfg_rd_wait(rdw), .cfg_wr_wait(wrw), .cfg_rd_swap(rsw), .cfg_wr_swap(wsw),
        .cfg_rd_only(ro), .cfg_wr_only(wo), .cfg_berr_en(berr), .cfg_irq_en(irqen),
        .req_valid(valid), .req_ready(ready), .req_write(wr), .req_region(rg),
        .req_addr(addr), .req_wdata(wdata), .rsp_done(done), .rsp_err(err),
        .rsp_rdata(rdata), .prot_irq(irq), .bus_cs_n(cs_n), .bus_rnw(rnw),
        .bus_addr(baddr), .bus_wdata(bwdata), .bus_wdata_oe(oe), .bus_rdata(rdata_in)
    );

    function automatic logic [31:0] rev(input logic [31:0] d);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = d[8*(3-i) +: 8];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input bit w, input logic [1:0] r, input logic [23:0] a, input logic [31:0] d);
        bit blocked, viol;
        int nw;
        string tg;
        logic [31:0] last;
        logic [3:0] csx;
        blocked = !(master && en[r]);
        viol    = w ? ro[r] : wo[r];
        nw      = w ? int'(wrw[r]) : int'(rdw[r]);
        @(negedge clk);
        chk("R11 ready idle", ready, 1);
        valid = 1; wr = w; rg = r; addr = a; wdata = d;
        @(negedge clk);
        valid = 0;
        chk("R11 ready busy", ready, 0);
        if (blocked || viol) begin
            tg = blocked ? "R9" : (w ? "R7" : "R8");
            chk({tg, " no cs"}, cs_n, 4'hF);
            chk({tg, " done"}, done, 1);
            chk({tg, " err"}, err, blocked ? 1'b1 : berr);
            chk({tg, " irq"}, irq, blocked ? 1'b0 : irqen);
        end else begin
            tg = (nw == 0) ? "R4" : (w ? "R3" : "R2");
            csx = ~(4'b1 << r);
            last = '0;
            for (int c = 0; c <= nw; c++) begin
                chk({tg, " cs low"}, cs_n, csx);
                chk({tg, " rnw"}, rnw, !w);
                chk({tg, " oe"}, oe, w);
                chk({tg, " addr"}, baddr, a);
                if (w) chk("R6 wdata lanes", bwdata, wsw[r] ? rev(d) : d);
                chk("R11 ready busy", ready, 0);
                last = $urandom;
                rdata_in = last;
                @(negedge clk);
            end
            chk({tg, " cs released"}, cs_n, 4'hF);
            chk("R5 done", done, 1);
            chk("R5 err", err, 0);
            chk("R5 irq", irq, 0);
            if (!w) chk("R6 R5 rdata", rdata, rsw[r] ? rev(last) : last);
        end
        @(negedge clk);
        chk("R5 done pulse", done, 0);
        chk("R11 ready back", ready, 1);
    endtask

    task automatic cfg_base();
        master = 1; en = 4'hF; rsw = 0; wsw = 0; ro = 0; wo = 0;
        rdw = '0; wrw = '0; berr = 1; irqen = 1;
    endtask

    initial begin
        void'($urandom(32'h1C5E_0042));
        cfg_base();
        repeat (3) @(negedge clk);
        chk("R1 cs", cs_n, 4'hF);
        chk("R1 ready", ready, 1);
        chk("R1 done", done, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1;
        // R4 zero waits, read and write
        run(0, 2'd0, 24'h000010, 32'h0);
        run(1, 2'd1, 24'h0000A4, 32'h11223344);
        // R2 R3 long waits with swaps (R6)
        rdw[2] = 4'd15; rsw[2] = 1; run(0, 2'd2, 24'hABCDEF, 32'h0);
        wrw[3] = 4'd7;  wsw[3] = 1; run(1, 2'd3, 24'h123456, 32'hA1B2C3D4);
        // R7 read-only write, error only / irq only
        ro[1] = 1; berr = 1; irqen = 0; run(1, 2'd1, 24'h5, 32'hDEAD);
        berr = 0; irqen = 1; run(1, 2'd1, 24'h6, 32'hBEEF);
        rdw[1] = 4'd2; run(0, 2'd1, 24'h7, 32'h0);
        // R8 write-only read
        wo[0] = 1; berr = 1; irqen = 1; run(0, 2'd0, 24'h8, 32'h0);
        wrw[0] = 4'd1; run(1, 2'd0, 24'h9, 32'h55AA);
        // R9 disabled region and master off
        en[3] = 0; run(1, 2'd3, 24'hA, 32'h1);
        en[3] = 1; master = 0; run(0, 2'd2, 24'hB, 32'h0);
        master = 1;
        for (int n = 0; n < 400; n++) begin
            master = ($urandom_range(15, 0) != 0);
            en = $urandom | 4'h7;
            if ($urandom_range(7, 0) == 0) en = $urandom;
            rdw = $urandom; wrw = $urandom;
            rsw = $urandom; wsw = $urandom;
            ro = $urandom & $urandom; wo = $urandom & $urandom;
            berr = $urandom; irqen = $urandom;
            run($urandom, 2'($urandom_range(3, 0)), 24'($urandom), $urandom);
        end
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule